// File: doc/BRIEF.md
# Raster Structure and Standard Detector

The detector watches a 10-bit serial digital video word stream and finds the timing reference sequences that mark the end and the start of active video on each line. From their spacing it measures four raster values: total samples per line, active samples per line, total lines per frame and active lines per frame. The four values are published once per frame, at a fixed line. Between those points the published values do not change, so a host can read them without tearing.

Each published raster is compared against a small parameterised table of known formats, which gives a 5-bit standard code. A flywheel watches the published rasters over time and raises a lock bit once the format is steady. The standard code and the lock bit read zero whenever the receiver reports no input lock or the active-low bypass input is driven low. While either condition holds, the flywheel starts over.

Top module: `raster_std_detect`

## Requirements
- R1: A word taken with `valid_i` high is a reference word when the three valid words before it were 3FFh, 000h, 000h. In that word, bit 8 is the field flag F, bit 7 is the vertical blanking flag V and bit 6 is H: 1 marks end of active video (EAV) and 0 marks start of active video (SAV). Words taken with `valid_i` low are ignored and are not counted.
- R2: The total sample count of a line is the number of valid words from one EAV reference word to the next.
- R3: The active sample count is the number of valid words from an SAV reference word to the next EAV reference word, minus 4.
- R4: A frame starts at an EAV whose F is 0 while the previous EAV had F=1. A frame also starts at an EAV with F=0 whose V is 1 while the previous EAV had V=0, but only when the previous frame held no F=1 line. The frame-start EAV begins line 1, each further EAV begins the next line, and no lines are counted before the first frame start.
- R5: The total line count is the number of lines in the previous complete frame. The active line count is the number of those lines whose EAV had V=0.
- R6: All four raster outputs are 0 after reset. They change only on the clock after the EAV that ends line 12. At that point they take the line's sample counts and the previous frame's line counts.
- R7: At each publish, the standard code becomes the code of the table entry whose four values all equal the published raster, or 0 when no entry matches.
- R8: The lock bit rises on the publish that repeats the raster of the publish just before it.
- R9: While locked, a single publish that differs from the locked raster keeps the lock. Two differing publishes in a row drop it.
- R10: While `lock_i` is low or `bypass_ni` is low, the standard code and the lock bit read 0, and the flywheel state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 10 | Video word |
| valid_i | input | 1 | Word qualifier |
| lock_i | input | 1 | Receiver lock, high when locked |
| bypass_ni | input | 1 | Bypass request, active low |
| tot_samp_o | output | 12 | Published total samples per line |
| act_samp_o | output | 12 | Published active samples per line |
| tot_lines_o | output | 11 | Published total lines per frame |
| act_lines_o | output | 11 | Published active lines per frame |
| std_code_o | output | 5 | Detected standard code |
| std_lock_o | output | 1 | Flywheel lock |

## Verification
A progressive raster in the table is sent repeatedly to show the code and lock being acquired. A raster whose line length is not in the table is then sent once, between good frames, to separate the keep-on-one-miss rule from the drop-on-two rule, and twice in a row to show the code falling to 0. Input lock and bypass are each pulled low mid-frame, which tells output gating apart from a flywheel restart. An interlaced raster, with idle cycles that carry 3FFh and 000h inserted, exercises the F-based frame start and shows that words without `valid_i` are neither counted nor matched.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int SAMP_W = 12;
  localparam int LINE_W = 11;
  localparam int CODE_W = 5;

  typedef struct packed {
    logic [SAMP_W-1:0] tot_samp;
    logic [SAMP_W-1:0] act_samp;
    logic [LINE_W-1:0] tot_lines;
    logic [LINE_W-1:0] act_lines;
  } raster_t;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    raster_t           raster;
  } std_entry_t;

  function automatic std_entry_t mk_entry(input int code, input int ts, input int as,
                                          input int tl, input int al);
    std_entry_t e;
    e.code             = CODE_W'(code);
    e.raster.tot_samp  = SAMP_W'(ts);
    e.raster.act_samp  = SAMP_W'(as);
    e.raster.tot_lines = LINE_W'(tl);
    e.raster.act_lines = LINE_W'(al);
    return e;
  endfunction
endpackage

// File: rtl/trs_detect.sv
module trs_detect #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              xyz_o,
  output logic              f_o,
  output logic              v_o,
  output logic              h_o
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] w1_q, w2_q, w3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1_q <= '0;
      w2_q <= '0;
      w3_q <= '0;
    end else if (valid_i) begin
      w3_q <= w2_q;
      w2_q <= w1_q;
      w1_q <= data_i;
    end
  end

  assign xyz_o = valid_i && (w3_q == ALL_ONES) && (w2_q == '0) && (w1_q == '0);
  assign f_o   = data_i[8];
  assign v_o   = data_i[7];
  assign h_o   = data_i[6];

  // R1: a reference word can never follow another one directly
  a_r1_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xyz_o |=> !xyz_o);
endmodule

// File: rtl/raster_measure.sv
module raster_measure
  import raster_pkg::*;
#(
  parameter int PUB_LINE = 12
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  logic    xyz_i,
  input  logic    f_i,
  input  logic    v_i,
  input  logic    h_i,
  output logic    pub_o,
  output raster_t new_o,
  output raster_t pub_q_o
);
  logic [SAMP_W-1:0] eav_cnt_q, sav_cnt_q;
  logic [LINE_W-1:0] line_q, act_cnt_q, lines_lat_q, act_lat_q;
  logic              prev_f_q, prev_v_q, ilace_q, fseen_q;
  raster_t           pub_q;
  logic              eav, sav, fs;
  logic [LINE_W-1:0] v_zero;

  assign eav    = xyz_i & h_i;
  assign sav    = xyz_i & ~h_i;
  assign fs     = (prev_f_q & ~f_i) | (~prev_v_q & v_i & ~f_i & ~ilace_q);
  assign pub_o  = eav && (line_q == LINE_W'(PUB_LINE));
  assign v_zero = {{(LINE_W-1){1'b0}}, ~v_i};

  assign new_o.tot_samp  = eav_cnt_q;
  assign new_o.act_samp  = sav_cnt_q - SAMP_W'(4);
  assign new_o.tot_lines = lines_lat_q;
  assign new_o.act_lines = act_lat_q;
  assign pub_q_o         = pub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eav_cnt_q   <= '0;
      sav_cnt_q   <= '0;
      line_q      <= '0;
      act_cnt_q   <= '0;
      lines_lat_q <= '0;
      act_lat_q   <= '0;
      prev_f_q    <= 1'b0;
      prev_v_q    <= 1'b0;
      ilace_q     <= 1'b0;
      fseen_q     <= 1'b0;
      pub_q       <= '0;
    end else if (valid_i) begin
      eav_cnt_q <= eav ? SAMP_W'(1) : eav_cnt_q + SAMP_W'(1);
      sav_cnt_q <= sav ? SAMP_W'(1) : sav_cnt_q + SAMP_W'(1);
      if (eav) begin
        prev_f_q <= f_i;
        prev_v_q <= v_i;
        if (fs) begin
          ilace_q     <= fseen_q | f_i;
          fseen_q     <= 1'b0;
          line_q      <= LINE_W'(1);
          act_cnt_q   <= v_zero;
          lines_lat_q <= line_q;
          act_lat_q   <= act_cnt_q;
        end else begin
          fseen_q <= fseen_q | f_i;
          if (line_q != '0) begin
            line_q    <= line_q + LINE_W'(1);
            act_cnt_q <= act_cnt_q + v_zero;
          end
        end
        if (pub_o) pub_q <= new_o;
      end
    end
  end

  a_r6_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pub_o |=> $stable(pub_q));
  a_r4_line_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eav && fs) |=> (line_q == LINE_W'(1)));
  a_r2_count_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav |=> (eav_cnt_q == SAMP_W'(1)));
endmodule

// File: rtl/std_flywheel.sv
module std_flywheel
  import raster_pkg::*;
#(
  parameter int                         NUM_STD   = 2,
  parameter std_entry_t [NUM_STD-1:0]   STD_TABLE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pub_i,
  input  raster_t           raster_i,
  output logic [CODE_W-1:0] code_o,
  output logic              sync_o
);
  logic [CODE_W-1:0] code_q, code_lu;
  logic              sync_q, miss_q, match;
  raster_t           ref_q;

  always_comb begin
    code_lu = '0;
    for (int i = 0; i < NUM_STD; i++)
      if (STD_TABLE[i].raster == raster_i) code_lu = STD_TABLE[i].code;
  end

  assign match = (raster_i == ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      sync_q <= 1'b0;
      miss_q <= 1'b0;
      ref_q  <= '0;
    end else if (!en_i) begin
      code_q <= '0;
      sync_q <= 1'b0;
      miss_q <= 1'b0;
      ref_q  <= '0;
    end else if (pub_i) begin
      code_q <= code_lu;
      if (!sync_q) begin
        ref_q <= raster_i;
        if (match) sync_q <= 1'b1;
      end else if (match) begin
        miss_q <= 1'b0;
      end else if (miss_q) begin
        sync_q <= 1'b0;
        miss_q <= 1'b0;
        ref_q  <= raster_i;
      end else begin
        miss_q <= 1'b1;
      end
    end
  end

  assign code_o = en_i ? code_q : '0;
  assign sync_o = en_i & sync_q;

  a_r10_state_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (code_q == '0 && !sync_q));
  a_r8_lock_on_publish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> $past(pub_i));
  a_r9_drop_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_q) |-> ($past(pub_i) || $past(!en_i)));
endmodule

// File: rtl/raster_std_detect.sv
module raster_std_detect
  import raster_pkg::*;
#(
  parameter int                       DATA_W    = 10,
  parameter int                       PUB_LINE  = 12,
  parameter int                       NUM_STD   = 2,
  parameter std_entry_t [NUM_STD-1:0] STD_TABLE = {mk_entry(2, 48, 32, 26, 20),
                                                   mk_entry(1, 40, 24, 20, 14)}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              lock_i,
  input  logic              bypass_ni,
  output logic [SAMP_W-1:0] tot_samp_o,
  output logic [SAMP_W-1:0] act_samp_o,
  output logic [LINE_W-1:0] tot_lines_o,
  output logic [LINE_W-1:0] act_lines_o,
  output logic [CODE_W-1:0] std_code_o,
  output logic              std_lock_o
);
  logic    xyz, f, v, h, pub;
  raster_t new_raster, pub_raster;

  trs_detect #(.DATA_W(DATA_W)) i_trs (
    .clk_i, .rst_ni, .data_i, .valid_i,
    .xyz_o(xyz), .f_o(f), .v_o(v), .h_o(h)
  );

  raster_measure #(.PUB_LINE(PUB_LINE)) i_meas (
    .clk_i, .rst_ni, .valid_i,
    .xyz_i(xyz), .f_i(f), .v_i(v), .h_i(h),
    .pub_o(pub), .new_o(new_raster), .pub_q_o(pub_raster)
  );

  std_flywheel #(.NUM_STD(NUM_STD), .STD_TABLE(STD_TABLE)) i_fly (
    .clk_i, .rst_ni, .en_i(lock_i & bypass_ni), .pub_i(pub),
    .raster_i(new_raster), .code_o(std_code_o), .sync_o(std_lock_o)
  );

  assign tot_samp_o  = pub_raster.tot_samp;
  assign act_samp_o  = pub_raster.act_samp;
  assign tot_lines_o = pub_raster.tot_lines;
  assign act_lines_o = pub_raster.act_lines;
endmodule

// File: tb/test_raster_std_detect.sv
module test_raster_std_detect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  data_i = '0;
  logic        valid_i = 1'b0;
  logic        lock_i = 1'b1;
  logic        bypass_ni = 1'b1;
  logic [11:0] tot_samp_o, act_samp_o;
  logic [10:0] tot_lines_o, act_lines_o;
  logic [4:0]  std_code_o;
  logic        std_lock_o;

  int n_tests = 0, n_fail = 0, gap_ctr = 0, cyc = 0;
  bit gap_en = 0, done = 0;

  always #2 clk_i = ~clk_i;

  raster_std_detect i_raster_std_detect (.*);

  // reference model state
  int m_w1, m_w2, m_w3, m_eav, m_sav, m_line, m_act, m_llat, m_alat;
  bit m_pf, m_pv, m_il, m_fs;
  int r_ts, r_as, r_tl, r_al, m_code;
  bit m_sync, m_miss;
  int ref_ts, ref_as, ref_tl, ref_al;

  function automatic int lookup(int ts, int as, int tl, int al);
    if (ts == 40 && as == 24 && tl == 20 && al == 14) return 1;
    if (ts == 48 && as == 32 && tl == 26 && al == 20) return 2;
    return 0;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_w1 = 0; m_w2 = 0; m_w3 = 0; m_eav = 0; m_sav = 0; m_line = 0; m_act = 0;
      m_llat = 0; m_alat = 0; m_pf = 0; m_pv = 0; m_il = 0; m_fs = 0;
      r_ts = 0; r_as = 0; r_tl = 0; r_al = 0; m_code = 0; m_sync = 0; m_miss = 0;
      ref_ts = 0; ref_as = 0; ref_tl = 0; ref_al = 0;
    end else begin
      bit pub, xyz, f, v, h, fs;
      int n_ts, n_as, n_tl, n_al;
      pub = 0; xyz = 0; f = 0; v = 0; h = 0;
      n_ts = 0; n_as = 0; n_tl = 0; n_al = 0;
      if (valid_i) begin
        xyz = (m_w3 == 1023 && m_w2 == 0 && m_w1 == 0);
        f = data_i[8]; v = data_i[7]; h = data_i[6];
        if (xyz && h) begin
          n_ts = m_eav; n_as = (m_sav - 4) & 4095; n_tl = m_llat; n_al = m_alat;
          pub = (m_line == 12);
          fs = (m_pf && !f) || (!m_pv && v && !f && !m_il);
          if (fs) begin
            m_il = m_fs || f; m_fs = 0; m_llat = m_line; m_alat = m_act;
            m_line = 1; m_act = v ? 0 : 1;
          end else begin
            m_fs = m_fs || f;
            if (m_line != 0) begin
              m_line = (m_line + 1) & 2047;
              m_act  = (m_act + (v ? 0 : 1)) & 2047;
            end
          end
          m_pf = f; m_pv = v;
          if (pub) begin r_ts = n_ts; r_as = n_as; r_tl = n_tl; r_al = n_al; end
        end
        m_eav = (xyz && h) ? 1 : (m_eav + 1) & 4095;
        m_sav = (xyz && !h) ? 1 : (m_sav + 1) & 4095;
        m_w3 = m_w2; m_w2 = m_w1; m_w1 = data_i;
      end
      if (!(lock_i && bypass_ni)) begin
        m_code = 0; m_sync = 0; m_miss = 0;
        ref_ts = 0; ref_as = 0; ref_tl = 0; ref_al = 0;
      end else if (pub) begin
        bit mt;
        mt = (n_ts == ref_ts && n_as == ref_as && n_tl == ref_tl && n_al == ref_al);
        m_code = lookup(n_ts, n_as, n_tl, n_al);
        if (!m_sync) begin
          ref_ts = n_ts; ref_as = n_as; ref_tl = n_tl; ref_al = n_al;
          if (mt) m_sync = 1;
        end else if (mt) m_miss = 0;
        else if (m_miss) begin
          m_sync = 0; m_miss = 0;
          ref_ts = n_ts; ref_as = n_as; ref_tl = n_tl; ref_al = n_al;
        end else m_miss = 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit en;
      en = lock_i && bypass_ni;
      chk("R2 tot_samp", tot_samp_o, r_ts);
      chk("R3 act_samp", act_samp_o, r_as);
      chk("R4/R5 tot_lines", tot_lines_o, r_tl);
      chk("R5 act_lines", act_lines_o, r_al);
      chk("R7 std_code", std_code_o, en ? m_code : 0);
      chk("R8/R9 std_lock", std_lock_o, en ? m_sync : 0);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic send_word(input logic [9:0] w);
    if (gap_en && (gap_ctr % 5 == 2)) begin
      valid_i = 1'b0;
      data_i  = (gap_ctr % 2 == 0) ? 10'h3FF : 10'h000;
      @(posedge clk_i); #1;
    end
    gap_ctr++;
    valid_i = 1'b1;
    data_i  = w;
    @(posedge clk_i); #1;
  endtask

  task automatic send_line(int tot, int act, bit f, bit v);
    send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
    send_word({1'b1, f, v, 1'b1, 6'b0});
    for (int i = 0; i < tot - 8 - act; i++) send_word(10'h040);
    send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
    send_word({1'b1, f, v, 1'b0, 6'b0});
    for (int i = 0; i < act; i++) send_word(10'h200 + 10'(i % 64));
  endtask

  task automatic send_prog(int tot, int act, int lines, int alines);
    for (int ln = 0; ln < lines; ln++) send_line(tot, act, 1'b0, ln < lines - alines);
  endtask

  task automatic send_ilace(int tot, int act, int lines, int alines);
    for (int fld = 0; fld < 2; fld++)
      for (int ln = 0; ln < lines / 2; ln++)
        send_line(tot, act, fld[0], ln < (lines - alines) / 2);
  endtask

  task automatic at_negedge();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    at_negedge();
    // R6: outputs zero after reset
    chk("R6 reset tot_samp", tot_samp_o, 0);
    chk("R6 reset tot_lines", tot_lines_o, 0);
    chk("R7 reset code", std_code_o, 0);
    chk("R8 reset lock", std_lock_o, 0);
    @(posedge clk_i); #1;

    // progressive table raster: acquire code and lock
    repeat (3) send_prog(40, 24, 20, 14);
    at_negedge();
    chk("R2 total samples", tot_samp_o, 40);
    chk("R3 active samples", act_samp_o, 24);
    chk("R5 total lines", tot_lines_o, 20);
    chk("R5 active lines", act_lines_o, 14);
    chk("R7 code for table raster", std_code_o, 1);
    chk("R8 lock after repeat", std_lock_o, 1);
    @(posedge clk_i); #1;

    // single off-table frame keeps lock
    send_prog(44, 28, 20, 14);
    at_negedge();
    chk("R9 lock kept after one miss", std_lock_o, 1);
    chk("R7 code for unknown raster", std_code_o, 0);
    @(posedge clk_i); #1;
    send_prog(40, 24, 20, 14);
    // two misses in a row drop lock
    send_prog(44, 28, 20, 14);
    send_prog(44, 28, 20, 14);
    at_negedge();
    chk("R9 lock dropped after two misses", std_lock_o, 0);
    @(posedge clk_i); #1;

    // receiver lock lost mid-frame
    send_prog(40, 24, 20, 14);
    send_prog(40, 24, 20, 14);
    for (int ln = 0; ln < 14; ln++) begin
      send_line(40, 24, 1'b0, ln < 6);
      if (ln == 4) lock_i = 1'b0;
    end
    at_negedge();
    chk("R10 code zero without lock", std_code_o, 0);
    chk("R10 lock bit zero without lock", std_lock_o, 0);
    @(posedge clk_i); #1;
    for (int ln = 14; ln < 20; ln++) send_line(40, 24, 1'b0, 1'b0);
    lock_i = 1'b1;
    send_prog(40, 24, 20, 14);
    at_negedge();
    chk("R10 flywheel restarted after lock loss", std_lock_o, 0);
    @(posedge clk_i); #1;
    send_prog(40, 24, 20, 14);
    at_negedge();
    chk("R8 relock", std_lock_o, 1);
    @(posedge clk_i); #1;

    // bypass asserted
    bypass_ni = 1'b0;
    send_line(40, 24, 1'b0, 1'b1);
    at_negedge();
    chk("R10 code zero in bypass", std_code_o, 0);
    chk("R10 lock zero in bypass", std_lock_o, 0);
    chk("R6 raster kept in bypass", tot_samp_o, 40);
    @(posedge clk_i); #1;
    bypass_ni = 1'b1;
    for (int ln = 1; ln < 20; ln++) send_line(40, 24, 1'b0, ln < 6);

    // interlaced raster with idle cycles carrying 3FFh and 000h
    gap_en = 1;
    repeat (3) send_ilace(48, 32, 26, 20);
    at_negedge();
    chk("R1 samples ignore idle words", tot_samp_o, 48);
    chk("R4 interlaced frame lines", tot_lines_o, 26);
    chk("R5 interlaced active lines", act_lines_o, 20);
    chk("R7 interlaced code", std_code_o, 2);
    chk("R8 interlaced lock", std_lock_o, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule